// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a four-level radix tree in memory. A request carries the virtual address and the physical base of the root table. The walker splits bits 47:12 into four 9-bit indices and reads one 8-byte entry per visited level through a single-outstanding request/response memory port. After each read it does one of three things: it descends into the next table, it stops with a fault, or it stops at a data page. When it stops at a data page it adds the untranslated low address bits to the page base.

Pages of 4KB come from the last level. The third and second levels may also end the walk with a 1GB or a 2MB page. An address whose upper bits are not a sign extension of bit 47 is rejected before any memory read. The walker handles one request at a time. It reports each result with a one-cycle `done` pulse and only then accepts the next request.

Top module: `ptw_walker`

## Requirements
- R1: When bits 63:48 of `req_va` are not all equal to bit 47, the accepted request ends with `done` and `done_fault` high in the cycle after acceptance, and no memory request is made. An address in the upper half whose bits 63:47 are all ones is translated normally.
- R2: Each entry address is the current table base with bits 11:0 cleared, plus the level's 9-bit index times 8. The first table base is `root_base`, and each later base is bits 51:12 of the entry just read. The index fields are `req_va` bits 47:39, 38:30, 29:21 and 20:12, visited in that order.
- R3: An entry with bit 0 (present) clear ends the walk at any level with `done_fault`=1, `done_pa`=0 and `done_size`=0, and no further memory request follows.
- R4: A present entry at the last level gives a 4KB page: `done_pa` = (entry bits 51:12 shifted left by 12) + `req_va` bits 11:0, with `done_size`=0 after four memory reads.
- R5: A present entry at the third level with bit 7 set gives a 1GB page: `done_pa` = (entry bits 51:30 shifted left by 30) + `req_va` bits 29:0, with `done_size`=2 after two reads. Entry bits 29:12 are ignored.
- R6: A present entry at the second level with bit 7 set gives a 2MB page: `done_pa` = (entry bits 51:21 shifted left by 21) + `req_va` bits 20:0, with `done_size`=1 after three reads. Entry bits 20:12 are ignored.
- R7: Bit 7 has no effect at the top level, where the walk still descends, or at the last level, where the result is still a 4KB page.
- R8: Exactly one memory request is made per visited level. `mem_req_valid` is a one-cycle pulse, and the walker then waits for `mem_rsp_valid`, however many cycles it takes.
- R9: `req_ready` is high only while idle, so `req_valid` during a walk is ignored. `done` lasts one cycle and `req_ready` returns in the following cycle.
- R10: While `rst` is high and after it falls, `req_ready`=1, `done`=0 and `mem_req_valid`=0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | 64 | Virtual address to translate |
| root_base | input | 52 | Physical base of the top-level table |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | 52 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_data | input | 64 | Entry read data |
| done | output | 1 | One-cycle result pulse |
| done_fault | output | 1 | Walk ended without a translation |
| done_pa | output | 52 | Translated physical address |
| done_size | output | 2 | Page size code: 0=4KB, 1=2MB, 2=1GB |

## Verification
Some properties are checked on every cycle. These are the single-cycle request and done pulses, entry-address alignment, and the read count bound per walk. They also cover how a page size matches the number of reads taken, the zeroed result on a fault, and the one-cycle rejection of a non-canonical address. Other behaviour only the bench scenarios can show. That includes whether each entry address points at the right slot, whether the physical address sums base and offset correctly for each page size, and whether bit 7 is ignored at the top and last levels. It also covers whether requests made during a walk are dropped and whether slow memory responses are waited for. The bench builds its own tables in a sparse memory model, and an absent slot reads as a non-present entry, so a wrong entry address shows up as a fault.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    localparam int VA_W        = 64;
    localparam int VA_TOP_BIT  = 47;
    localparam int PA_W        = 52;
    localparam int ENTRY_W     = 64;
    localparam int PAGE_SHIFT  = 12;
    localparam int IDX_W       = 9;
    localparam int LEVELS      = 4;
    localparam int LVL_W       = $clog2(LEVELS);
    localparam int CNT_W       = $clog2(LEVELS + 1);
    localparam int ENTRY_SHIFT = 3;
    localparam int PRESENT_BIT = 0;
    localparam int LARGE_BIT   = 7;
    // levels (by index, 0 = last) where a large-page leaf is honoured
    localparam logic [LEVELS-1:0] LARGE_OK = 4'b0110;

    typedef logic [PA_W-1:0]    pa_t;
    typedef logic [VA_W-1:0]    va_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        ACT_DESCEND,
        ACT_LEAF,
        ACT_FAULT
    } entry_act_e;

    typedef struct packed {
        entry_act_e act;
        pg_size_e   size;
        pa_t        base;
    } entry_dec_t;

    typedef struct packed {
        logic     fault;
        pg_size_e size;
        pa_t      pa;
    } walk_result_t;

    function automatic pg_size_e lvl_size(input lvl_t lvl);
        case (lvl)
            lvl_t'(1): return PG_2M;
            lvl_t'(2): return PG_1G;
            default:   return PG_4K;
        endcase
    endfunction

    function automatic pa_t align_page(input pa_t a);
        return {a[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/ptw_va_split.sv
`timescale 1ns/1ps
module ptw_va_split
    import ptw_pkg::*;
(
    input  va_t  va,
    output logic canonical,
    output idx_t idx [LEVELS]
);
    localparam int EXT_W = VA_W - VA_TOP_BIT;

    logic [EXT_W-1:0] ext_bits;
    assign ext_bits  = va[VA_W-1:VA_TOP_BIT];
    assign canonical = (ext_bits == {EXT_W{1'b0}}) || (ext_bits == {EXT_W{1'b1}});

    logic unused_va_lo;
    assign unused_va_lo = ^va[PAGE_SHIFT-1:0];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_idx
            assign idx[g] = va[PAGE_SHIFT + IDX_W*g +: IDX_W];
        end
    endgenerate
endmodule

// File: rtl/ptw_entry_decode.sv
`timescale 1ns/1ps
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  entry_t     entry,
    input  lvl_t       lvl,
    output entry_dec_t dec
);
    logic unused_entry;
    assign unused_entry = ^{entry[ENTRY_W-1:PA_W],
                            entry[PAGE_SHIFT-1:LARGE_BIT+1],
                            entry[LARGE_BIT-1:PRESENT_BIT+1]};

    always_comb begin
        dec.act  = ACT_DESCEND;
        dec.size = PG_4K;
        dec.base = {entry[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        if (!entry[PRESENT_BIT]) begin
            dec.act = ACT_FAULT;
        end else if (lvl == '0) begin
            dec.act  = ACT_LEAF;
            dec.size = PG_4K;
        end else if (entry[LARGE_BIT] && LARGE_OK[lvl]) begin
            dec.act  = ACT_LEAF;
            dec.size = lvl_size(lvl);
        end
    end
endmodule

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  pa_t  node,
    input  idx_t idx,
    output pa_t  addr
);
    assign addr = align_page(node) + (pa_t'(idx) << ENTRY_SHIFT);
endmodule

// File: rtl/ptw_leaf_form.sv
`timescale 1ns/1ps
module ptw_leaf_form
    import ptw_pkg::*;
(
    input  pa_t  base,
    input  va_t  va,
    input  lvl_t lvl,
    output pa_t  pa
);
    pa_t cand [LEVELS];

    logic unused_va_hi;
    assign unused_va_hi = ^va[VA_W-1:PA_W];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
            localparam int OFF_W = PAGE_SHIFT + IDX_W*g;
            pa_t off_mask;
            assign off_mask = pa_t'((64'd1 << OFF_W) - 64'd1);
            assign cand[g]  = (base & ~off_mask) + (va[PA_W-1:0] & off_mask);
        end
    endgenerate

    assign pa = cand[lvl];
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_va,
    input  logic [51:0] root_base,
    output logic        mem_req_valid,
    output logic [51:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    output logic        done,
    output logic        done_fault,
    output logic [51:0] done_pa,
    output logic [1:0]  done_size
);
    walk_state_e  state_q;
    lvl_t         lvl_q;
    pa_t          node_q;
    va_t          va_q;
    walk_result_t res_q;
    cnt_t         reqs_q;

    va_t        split_va;
    logic       canonical;
    idx_t       idx [LEVELS];
    entry_dec_t dec;
    pa_t        leaf_pa;
    pa_t        entry_addr;

    assign split_va = (state_q == ST_IDLE) ? req_va : va_q;

    ptw_va_split u_split (
        .va        (split_va),
        .canonical (canonical),
        .idx       (idx)
    );

    ptw_entry_addr u_addr (
        .node (node_q),
        .idx  (idx[lvl_q]),
        .addr (entry_addr)
    );

    ptw_entry_decode u_dec (
        .entry (mem_rsp_data),
        .lvl   (lvl_q),
        .dec   (dec)
    );

    ptw_leaf_form u_leaf (
        .base (dec.base),
        .va   (va_q),
        .lvl  (lvl_q),
        .pa   (leaf_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            node_q  <= '0;
            va_q    <= '0;
            res_q   <= '0;
            reqs_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        node_q <= root_base;
                        lvl_q  <= lvl_t'(LEVELS - 1);
                        reqs_q <= '0;
                        res_q  <= '0;
                        if (!canonical) begin
                            res_q.fault <= 1'b1;
                            state_q     <= ST_DONE;
                        end else begin
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    reqs_q  <= reqs_q + 1'b1;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        case (dec.act)
                            ACT_FAULT: begin
                                res_q.fault <= 1'b1;
                                state_q     <= ST_DONE;
                            end
                            ACT_LEAF: begin
                                res_q.pa   <= leaf_pa;
                                res_q.size <= dec.size;
                                state_q    <= ST_DONE;
                            end
                            default: begin
                                node_q  <= dec.base;
                                lvl_q   <= lvl_q - 1'b1;
                                state_q <= ST_REQ;
                            end
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_REQ);
    assign mem_req_addr  = entry_addr;
    assign done          = (state_q == ST_DONE);
    assign done_fault    = res_q.fault;
    assign done_pa       = res_q.pa;
    assign done_size     = res_q.size;

    AST_NONCANON_FAST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !canonical) |=> (done && done_fault && reqs_q == '0))
        else $error("non-canonical request not rejected at once"); // R1

    AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[ENTRY_SHIFT-1:0] == '0))
        else $error("entry address not 8-byte aligned"); // R2

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault) |-> (done_pa == '0 && done_size == 2'd0))
        else $error("fault result carries data"); // R3

    AST_SIZE_4K_READS: assert property (@(posedge clk) disable iff (rst)
        (done && !done_fault && done_size == PG_4K) |-> (reqs_q == cnt_t'(LEVELS)))
        else $error("4KB page without a full walk"); // R4

    AST_SIZE_1G_READS: assert property (@(posedge clk) disable iff (rst)
        (done && !done_fault && done_size == PG_1G) |-> (reqs_q == cnt_t'(LEVELS - 2)))
        else $error("1GB page with wrong read count"); // R5

    AST_SIZE_2M_READS: assert property (@(posedge clk) disable iff (rst)
        (done && !done_fault && done_size == PG_2M) |-> (reqs_q == cnt_t'(LEVELS - 1)))
        else $error("2MB page with wrong read count"); // R6

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid)
        else $error("memory request longer than one cycle"); // R8

    AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (reqs_q <= cnt_t'(LEVELS)))
        else $error("more reads than levels"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready))
        else $error("done not a single pulse followed by ready"); // R9
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
    localparam logic [51:0] ROOT = 52'h0_0000_0010_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_va;
    logic [51:0] root_base;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done;
    logic        done_fault;
    logic [51:0] done_pa;
    logic [1:0]  done_size;

    always #2.5 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .root_base     (root_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .done_fault    (done_fault),
        .done_pa       (done_pa),
        .done_size     (done_size)
    );

    typedef struct {
        logic        fault;
        logic [51:0] pa;
        logic [1:0]  size;
        int          reqs;
        int          lat;
        int          start;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] mem [logic [51:0]];
    logic [51:0] next_tbl = 52'h0_0000_0020_0000;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          reqs_seen = 0;
    int          rsp_delay = 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mkva(input int t, input int a, input int b,
                                         input int c, input int off);
        logic [63:0] v;
        v = (64'(t & 511) << 39) | (64'(a & 511) << 30) | (64'(b & 511) << 21)
          | (64'(c & 511) << 12) | 64'(off & 12'hFFF);
        if (v[47]) v[63:48] = 16'hFFFF;
        return v;
    endfunction

    function automatic logic [51:0] slot(input logic [51:0] node, input logic [63:0] va,
                                         input int lvl);
        logic [51:0] ix;
        ix = 52'((va >> (12 + 9*lvl)) & 64'h1FF);
        return {node[51:12], 12'h000} + ix * 52'd8;
    endfunction

    // build tables for va down to leaf_lvl; the leaf entry is left out when absent
    task automatic map(input logic [63:0] va, input int leaf_lvl, input logic [51:0] page,
                       input logic [63:0] leaf_extra, input logic [63:0] top_extra,
                       input bit absent);
        logic [51:0] node;
        node = ROOT;
        for (int l = 3; l > leaf_lvl; l--) begin
            logic [51:0] a;
            a = slot(node, va, l);
            next_tbl = next_tbl + 52'h1000;
            mem[a] = {12'h000, next_tbl} | 64'h1 | ((l == 3) ? top_extra : 64'h0);
            node = next_tbl;
        end
        if (!absent) mem[slot(node, va, leaf_lvl)] = {12'h000, page} | 64'h1 | leaf_extra;
    endtask

    // memory responder
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [51:0] a;
                a = mem_req_addr;
                reqs_seen++;
                check(req_ready == 1'b0, "R8", "request while idle", 64'(req_ready), 64'd0);
                repeat (rsp_delay) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R9 unexpected done: actual pa %h expected none", done_pa);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(done_fault === e.fault, e.tag, "fault", 64'(done_fault), 64'(e.fault));
                check(done_pa === e.pa, e.tag, "pa", 64'(done_pa), 64'(e.pa));
                check(done_size === e.size, e.tag, "size", 64'(done_size), 64'(e.size));
                check(reqs_seen == e.reqs, e.tag, "reads", 64'(reqs_seen), 64'(e.reqs));
                if (e.lat > 0)
                    check(cyc - e.start == e.lat, e.tag, "latency", 64'(cyc - e.start), 64'(e.lat));
            end
            reqs_seen = 0;
        end
    end

    task automatic walk(input logic [63:0] va, input logic fault, input logic [51:0] pa,
                        input logic [1:0] size, input int reqs, input int lat,
                        input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.fault = fault; e.pa = pa; e.size = size; e.reqs = reqs;
        e.lat = lat; e.start = cyc; e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual no result expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] va;
        logic [51:0] pg;
        rst       = 1'b1;
        req_valid = 1'b0;
        req_va    = '0;
        root_base = ROOT;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready in reset", 64'(req_ready), 64'd1);
        check(done == 1'b0, "R10", "done in reset", 64'(done), 64'd0);
        check(mem_req_valid == 1'b0, "R10", "mem req in reset", 64'(mem_req_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0, "R10", "idle after reset",
              64'({req_ready, done}), 64'b10);

        // R4 + R2: plain 4KB walk
        va = mkva(1, 5, 7, 9, 12'hABC);
        pg = 52'h0_0001_2345_6000;
        map(va, 0, pg, 64'h0, 64'h0, 1'b0);
        walk(va, 1'b0, pg + 52'hABC, 2'd0, 4, 0, "R4");

        // R7: large bit at last level still 4KB
        va = mkva(2, 1, 2, 3, 12'h010);
        pg = 52'h0_0000_0777_7000;
        map(va, 0, pg, 64'h80, 64'h0, 1'b0);
        walk(va, 1'b0, pg + 52'h010, 2'd0, 4, 0, "R7");

        // R7: large bit at top level is ignored, walk descends
        va = mkva(3, 4, 5, 6, 12'h234);
        pg = 52'h0_0000_0888_8000;
        map(va, 0, pg, 64'h0, 64'h80, 1'b0);
        walk(va, 1'b0, pg + 52'h234, 2'd0, 4, 0, "R7");

        // R5: 1GB page at third level, junk in entry bits 29:12
        va = mkva(4, 9, 300, 77, 12'h5A5);
        pg = 52'd5 << 30;
        map(va, 2, pg, 64'h80 | 64'h1234_5000, 64'h0, 1'b0);
        walk(va, 1'b0, pg + 52'(va[29:0]), 2'd2, 2, 0, "R5");

        // R6: 2MB page at second level, junk in entry bits 20:12
        va = mkva(5, 2, 44, 311, 12'hFED);
        pg = 52'd77 << 21;
        map(va, 1, pg, 64'h80 | 64'h1_F000, 64'h0, 1'b0);
        walk(va, 1'b0, pg + 52'(va[20:0]), 2'd1, 3, 0, "R6");

        // R3: absent entries at top, second and last level
        va = mkva(6, 0, 0, 0, 0);
        walk(va, 1'b1, 52'h0, 2'd0, 1, 0, "R3");
        va = mkva(7, 3, 3, 3, 0);
        map(va, 1, 52'h0, 64'h0, 64'h0, 1'b1);
        walk(va, 1'b1, 52'h0, 2'd0, 3, 0, "R3");
        va = mkva(8, 8, 8, 8, 0);
        map(va, 0, 52'h0, 64'h0, 64'h0, 1'b1);
        walk(va, 1'b1, 52'h0, 2'd0, 4, 0, "R3");

        // R1: non-canonical addresses rejected without reads
        walk(64'h0001_0000_0000_0000, 1'b1, 52'h0, 2'd0, 0, 1, "R1");
        walk(64'hFFFF_0000_0000_1000, 1'b1, 52'h0, 2'd0, 0, 1, "R1");
        walk(64'h0000_8000_0000_0000, 1'b1, 52'h0, 2'd0, 0, 1, "R1");

        // R1 + R2: upper-half canonical address with all index fields at maximum
        va = mkva(511, 511, 511, 511, 12'hFFF);
        pg = 52'h0_000A_BCDE_F000;
        map(va, 0, pg, 64'h0, 64'h0, 1'b0);
        walk(va, 1'b0, pg + 52'hFFF, 2'd0, 4, 0, "R1");
        drain();

        // R8: slow memory responses are waited for
        rsp_delay = 4;
        va = mkva(1, 5, 7, 9, 12'h001);
        walk(va, 1'b0, 52'h0_0001_2345_6001, 2'd0, 4, 0, "R8");
        drain();
        rsp_delay = 1;

        // R9: requests during a walk are ignored
        va = mkva(2, 1, 2, 3, 12'h020);
        walk(va, 1'b0, 52'h0_0000_0777_7020, 2'd0, 4, 0, "R9");
        for (int i = 0; i < 6; i++) begin
            req_valid = 1'b1;
            req_va    = 64'h0001_0000_0000_0000;
            @(negedge clk);
            check(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
        end
        req_valid = 1'b0;
        drain();
        check(req_ready == 1'b1, "R9", "ready after done", 64'(req_ready), 64'd1);
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule